// File: doc/BRIEF.md
# Radix-8 Digit-Swap Ping-Pong Reorder Buffer

This block sits between two radix-8 stages of a 64-point transform. It takes a stream of complex samples, one per cycle, and collects them into 64-sample frames. It holds two frames in two banks. While the upstream stage fills one bank, the downstream stage drains the other. After each frame the two banks swap roles. A frame is read out only once all 64 of its samples have been written.

On the read side, each frame is drained either in natural order or in base-8 digit-swapped order. Output position n = 8a + b fetches the sample that was written at index 8b + a. This swap turns a stream that arrives as 0, 8, 16, …, 56, 1, 9, … back into natural order, and the same swap also does the reverse conversion. The order is chosen per frame. The input has a ready signal that drops only when both banks hold full frames. The output uses a valid/ready handshake, so a slow consumer holds the data in place.

There are two small state machines. The write side has states WR_FILL (accepting samples into the current write bank) and WR_WAIT (the next bank still holds an unread frame). Its transitions are: fill-to-wait, taken when the 64th write completes and the other bank is still full; and wait-to-fill, taken when the reader frees that bank. The read side has states RD_IDLE (the current read bank is empty) and RD_DRAIN (the bank holds a complete frame and is being emitted). Its transitions are: idle-to-drain, taken when the bank becomes full; drain-to-drain, taken at a frame end when the other bank is already full; and drain-to-idle, taken at a frame end when the other bank is not yet full.

Top module: `octal_reorder_pp`

## Requirements
- R1: During reset and just after it, out_valid is 0 and in_ready is 1.
- R2: A frame's first out_valid appears only after that frame's 64th accepted sample. With the output bank empty beforehand, it appears on the clock edge that accepts that 64th sample.
- R3: With mode_nat = 0 (swap order), output position n = 8a + b (a, b in 0..7) carries the sample written at frame index 8b + a. For example, position 1 carries index 8.
- R4: With mode_nat = 1 (natural order), output position n carries the sample written at frame index n.
- R5: The order for a frame is taken from mode_nat when that frame's position 0 is transferred. Changes of mode_nat during positions 1..63 do not affect that frame.
- R6: With in_valid held high and out_ready held high, in_ready never drops and out_valid stays high without gaps across consecutive frames once the first frame is complete.
- R7: While out_valid = 1 and out_ready = 0, out_valid stays 1 and out_re/out_im hold their values on the next cycle.
- R8: When both banks hold unread frames, in_ready is 0. Samples offered with in_valid = 1 in that time are dropped and never appear at the output.
- R9: Cycles with in_valid = 0 write nothing. A frame written with gaps is stored in the order of its accepted samples.
- R10: When the writer is accepting and the reader is emitting in the same cycle, they use different banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Buffer can accept a sample this cycle |
| in_re | input | SAMPLE_W | Input real part |
| in_im | input | SAMPLE_W | Input imaginary part |
| mode_nat | input | 1 | 1 = natural read order, 0 = base-8 digit-swapped read order |
| out_valid | output | 1 | Output sample is present |
| out_ready | input | 1 | Consumer takes the sample this cycle |
| out_re | output | SAMPLE_W | Output real part |
| out_im | output | SAMPLE_W | Output imaginary part |

## Verification
If a bank-full flag is lost or stuck, the fault shows at the ports within one frame. A stale frame repeats, a frame is skipped, in_ready drops while a bank is free, or a gap appears in a continuous stream. If the read counter or the digit swap is wrong, the very next transferred sample carries the wrong tagged index. Every sample is encoded with its frame and index, so any misordering or lost frame is pinned to the exact position where it first happens.

// File: rtl/oct_reorder_pkg.sv
package oct_reorder_pkg;

    typedef enum logic {
        WR_FILL,
        WR_WAIT
    } wr_state_t;

    typedef enum logic {
        RD_IDLE,
        RD_DRAIN
    } rd_state_t;

endpackage

// File: rtl/orp_bank_ram.sv
module orp_bank_ram #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/orp_write_ctrl.sv
module orp_write_ctrl
    import oct_reorder_pkg::*;
#(
    parameter int DIGIT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [1:0]             full_q,
    input  logic [1:0]             full_nxt,
    output logic                   wr_en,
    output logic                   wr_bank,
    output logic [2*DIGIT_W-1:0]   wr_idx,
    output logic                   wr_last,
    output logic                   in_ready
);
    localparam int IDX_W = 2 * DIGIT_W;

    wr_state_t        state_q, state_d;
    logic             bank_q, bank_d;
    logic [IDX_W-1:0] cnt_q;

    always_comb begin
        wr_en   = in_valid && (state_q == WR_FILL);
        wr_last = wr_en && (cnt_q == '1);
        bank_d  = bank_q ^ wr_last;
        unique case (state_q)
            WR_FILL: state_d = full_nxt[bank_d] ? WR_WAIT : WR_FILL;
            WR_WAIT: state_d = full_nxt[bank_q] ? WR_WAIT : WR_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WR_FILL;
            bank_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            bank_q  <= bank_d;
            if (wr_en) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        in_ready = (state_q == WR_FILL);
        wr_bank  = bank_q;
        wr_idx   = cnt_q;
    end

    // R8
    wr_into_free_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full_q[bank_q]);

    // R8
    ready_low_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q == 2'b11) |-> !in_ready);

endmodule

// File: rtl/orp_read_ctrl.sv
module orp_read_ctrl
    import oct_reorder_pkg::*;
#(
    parameter int DIGIT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   out_ready,
    input  logic                   mode_nat,
    input  logic [1:0]             full_q,
    input  logic [1:0]             full_nxt,
    output logic                   rd_bank,
    output logic [2*DIGIT_W-1:0]   rd_addr,
    output logic                   rd_last,
    output logic                   out_valid
);
    localparam int IDX_W = 2 * DIGIT_W;

    rd_state_t        state_q, state_d;
    logic             bank_q, bank_d;
    logic [IDX_W-1:0] cnt_q;
    logic             mode_q;
    logic             fire;
    logic             use_nat;

    always_comb begin
        out_valid = (state_q == RD_DRAIN);
        fire      = out_valid && out_ready;
        rd_last   = fire && (cnt_q == '1);
        bank_d    = bank_q ^ rd_last;
        unique case (state_q)
            RD_IDLE:  state_d = full_nxt[bank_d] ? RD_DRAIN : RD_IDLE;
            RD_DRAIN: state_d = full_nxt[bank_d] ? RD_DRAIN : RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            bank_q  <= 1'b0;
            cnt_q   <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            bank_q  <= bank_d;
            if (fire) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == '0) begin
                    mode_q <= mode_nat;
                end
            end
        end
    end

    // position 0 maps to address 0 either way, so the live mode is safe there
    always_comb begin
        use_nat = (cnt_q == '0) ? mode_nat : mode_q;
        rd_addr = use_nat ? cnt_q : {cnt_q[DIGIT_W-1:0], cnt_q[IDX_W-1:DIGIT_W]};
        rd_bank = bank_q;
    end

    // R2
    valid_only_on_full_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> full_q[bank_q]);

    // R7
    hold_on_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(rd_addr) && $stable(bank_q)));

endmodule

// File: rtl/octal_reorder_pp.sv
module octal_reorder_pp #(
    parameter int SAMPLE_W = 16,
    parameter int DIGIT_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_re,
    input  logic [SAMPLE_W-1:0] in_im,
    input  logic                mode_nat,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_re,
    output logic [SAMPLE_W-1:0] out_im
);
    localparam int IDX_W  = 2 * DIGIT_W;
    localparam int ADDR_W = IDX_W + 1;
    localparam int WORD_W = 2 * SAMPLE_W;

    logic [1:0]       full_q, full_nxt;
    logic             wr_en, wr_bank, wr_last;
    logic [IDX_W-1:0] wr_idx;
    logic             rd_bank, rd_last;
    logic [IDX_W-1:0] rd_addr;
    logic [WORD_W-1:0] rdata;

    always_comb begin
        full_nxt = full_q;
        if (wr_last) begin
            full_nxt[wr_bank] = 1'b1;
        end
        if (rd_last) begin
            full_nxt[rd_bank] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 2'b00;
        end else begin
            full_q <= full_nxt;
        end
    end

    orp_write_ctrl #(.DIGIT_W(DIGIT_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .full_q   (full_q),
        .full_nxt (full_nxt),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_idx   (wr_idx),
        .wr_last  (wr_last),
        .in_ready (in_ready)
    );

    orp_read_ctrl #(.DIGIT_W(DIGIT_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_ready (out_ready),
        .mode_nat  (mode_nat),
        .full_q    (full_q),
        .full_nxt  (full_nxt),
        .rd_bank   (rd_bank),
        .rd_addr   (rd_addr),
        .rd_last   (rd_last),
        .out_valid (out_valid)
    );

    orp_bank_ram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr ({wr_bank, wr_idx}),
        .wdata ({in_re, in_im}),
        .raddr ({rd_bank, rd_addr}),
        .rdata (rdata)
    );

    assign out_re = rdata[WORD_W-1:SAMPLE_W];
    assign out_im = rdata[SAMPLE_W-1:0];

    // R10
    banks_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && out_valid) |-> (wr_bank != rd_bank));

    // R2
    first_valid_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(wr_last));

endmodule

// File: tb/octal_reorder_pp_test.sv
module octal_reorder_pp_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_re, in_im;
    logic        mode_nat;
    logic        out_valid;
    logic        out_ready;
    logic [15:0] out_re, out_im;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    octal_reorder_pp #(.SAMPLE_W(16), .DIGIT_W(3)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_re     (in_re),
        .in_im     (in_im),
        .mode_nat  (mode_nat),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] tag(input int f, input int i);
        return 16'(f * 64 + i);
    endfunction

    task automatic produce(input int f0, input int nf, input bit gaps,
                           input bit need_ready, input bit expect_idle);
        int f = f0;
        int i = 0;
        while (f < f0 + nf) begin
            @(negedge clk);
            in_valid = !(gaps && (cyc % 3 == 0));
            in_re    = tag(f, i);
            in_im    = tag(f, i) ^ 16'hA000;
            if (need_ready) check(in_ready == 1'b1, "R6 in_ready", int'(in_ready), 1);
            if (expect_idle) check(out_valid == 1'b0, "R2 early valid", int'(out_valid), 0);
            if (in_valid && in_ready) begin
                i++;
                if (i == 64) begin
                    i = 0;
                    f++;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic consume(input int f0, input int nf, input bit stalls, input bit gapless);
        int f = f0;
        int n = 0;
        bit started = 0;
        bit held = 0;
        bit base;
        int idx;
        logic [15:0] ev, hre, him;
        string req;
        while (f < f0 + nf) begin
            @(negedge clk);
            base      = f[0];
            mode_nat  = (n == 0) ? base : ((f >= 2) ? ~base : base);
            out_ready = !(stalls && (cyc % 5 == 3));
            #1;
            if (held) begin
                check(out_valid && out_re == hre && out_im == him, "R7 hold",
                      int'(out_re), int'(hre));
                held = 0;
            end
            if (out_valid) begin
                started = 1;
                idx = base ? n : ((n % 8) * 8 + n / 8);
                ev  = tag(f, idx);
                if (f >= 2)      req = "R5 frozen mode";
                else if (f == 0) req = "R3 R9 swap order";
                else             req = "R4 natural order";
                check(out_re == ev && out_im == (ev ^ 16'hA000), req, int'(out_re), int'(ev));
                if (out_ready) begin
                    n++;
                    if (n == 64) begin
                        n = 0;
                        f++;
                    end
                end else begin
                    held = 1;
                    hre  = out_re;
                    him  = out_im;
                end
            end else if (gapless && started) begin
                check(1'b0, "R6 output gap", 0, 1);
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_re     = '0;
        in_im     = '0;
        mode_nat  = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 post-reset valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 post-reset ready", int'(in_ready), 1);

        // R2 R9: frame 0 with input gaps; no output until complete
        produce(0, 1, 1'b1, 1'b0, 1'b1);
        #1;
        check(out_valid == 1'b1, "R2 valid after fill", int'(out_valid), 1);
        check(out_re == 16'd0, "R2 first sample", int'(out_re), 0);

        // R8: fill the second bank with the reader stalled
        produce(1, 1, 1'b0, 1'b0, 1'b0);
        check(in_ready == 1'b0, "R8 both full", int'(in_ready), 0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_re    = 16'hDEAD;
            in_im    = 16'hDEAD;
            #1;
            check(in_ready == 1'b0, "R8 still blocked", int'(in_ready), 0);
            check(out_valid && out_re == 16'd0, "R7 stalled output", int'(out_re), 0);
        end
        @(negedge clk);
        in_valid = 1'b0;

        // R3 R4 R5 R7 R8: drain with backpressure while more frames arrive
        fork
            consume(0, 6, 1'b1, 1'b0);
            produce(2, 4, 1'b0, 1'b0, 1'b0);
        join

        // R6: continuous traffic, no stalls either side
        fork
            consume(6, 3, 1'b0, 1'b1);
            produce(6, 3, 1'b0, 1'b1, 1'b0);
        join

        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R6 drained", int'(out_valid), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule